// File: doc/BRIEF.md
# DRAM Controller Power-State Sequencer

This block is the control state machine of a DRAM controller. Software moves it between four operating states by writing command codes: configuration, ready to serve memory traffic, paused, and low power (memory held in self-refresh). A two-bit status field reports the current state, and an accept flag tells the bus side whether memory accesses may be taken.

A second, hardware-driven path lets a system power manager put the controller into low power without software. It uses an active-low request with a matching acknowledge and an activity indication, in the manner of the AXI low-power handshake. In both paths, entry to and exit from self-refresh is confirmed by the memory-clock power logic through a level request/acknowledge pair, `sref_req` and `sref_ack`. The low-power state is left only after that logic has confirmed the exit. Everything runs on one clock.

Top module: `mc_pwr_seq`

## Requirements
- R1: After reset the status is 2'b00 (Config), `accept` is 0, `sref_req` is 0, `pwr_ack` is 1 and `pwr_active` is 1.
- R2: A Go command (code 3'd1) in Config moves the controller to Ready (status 2'b01) on the next clock edge. Go in Paused also moves it to Ready.
- R3: A Pause command (code 3'd2) in Ready moves it to Paused (status 2'b10).
- R4: A Configure command (code 3'd3) in Paused moves it to Config (status 2'b00).
- R5: A Sleep command (code 3'd4) is accepted only in Paused. It moves the controller to Low_power (status 2'b11) with `sref_req` high and `pwr_active` low.
- R6: A Wakeup command (code 3'd5) in a software Low_power takes effect only while `sref_ack` is high. It drops `sref_req`. The controller then enters Paused on the clock edge that sees `sref_ack` low. A Wakeup given before `sref_ack` rises is ignored.
- R7: Any command not legal in the current state, including the unused codes 0, 6 and 7, leaves the status and all outputs unchanged.
- R8: `pwr_req` low while Ready moves the controller to Low_power on the next edge. `pwr_ack` falls on the edge after `sref_ack` is seen high. In any state other than Ready, `pwr_req` low has no effect.
- R9: When `pwr_req` returns high during a hardware Low_power and `sref_ack` is high, `sref_req` drops. On the edge that sees `sref_ack` low, the controller returns to Ready with `pwr_ack` rising in the same cycle.
- R10: `accept` is 1 exactly when the status is Ready.
- R11: In Ready, a hardware request has priority over a command given in the same cycle. During a hardware Low_power, all commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | CMD_W | Command code |
| status | output | 2 | Current state encoding |
| accept | output | 1 | Memory accesses may be accepted |
| pwr_req | input | 1 | Hardware low-power request, active low |
| pwr_ack | output | 1 | Hardware low-power acknowledge, follows pwr_req |
| pwr_active | output | 1 | Low while in Low_power |
| sref_req | output | 1 | Self-refresh request toward memory-clock logic |
| sref_ack | input | 1 | Self-refresh acknowledge from memory-clock logic |

## Verification
On every cycle, the assertions check these relations: accept against status, the link between the self-refresh request and the Low_power state, the cycles in which the handshake acknowledge may change edge, the Go transition out of Config, the stability of status under unused codes, and the exit from Low_power once the self-refresh acknowledge drops. Only the bench scenarios can show the following: the whole software round trip through Sleep and Wakeup, the rejection of an early Wakeup, hardware priority over a command in the same cycle, and the ignoring of commands during a hardware low-power period. Mixed random command and request traffic is also compared cycle by cycle against a behavioural model.

// File: rtl/mcps_pkg.sv
package mcps_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [1:0] {
    ST_CFG = 2'b00,
    ST_RDY = 2'b01,
    ST_PAU = 2'b10,
    ST_LP  = 2'b11
  } mc_state_e;

  localparam logic [2:0] OP_GO    = 3'd1;
  localparam logic [2:0] OP_PAUSE = 3'd2;
  localparam logic [2:0] OP_CONF  = 3'd3;
  localparam logic [2:0] OP_SLEEP = 3'd4;
  localparam logic [2:0] OP_WAKE  = 3'd5;
endpackage

// File: rtl/mcps_rst_sync.sv
module mcps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sh_q[STAGES-1];
endmodule

// File: rtl/mcps_cmd_decode.sv
module mcps_cmd_decode
  import mcps_pkg::*;
#(
  parameter int CMD_W = mcps_pkg::CMD_W
) (
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  mc_state_e        state,
  input  logic             hw_lp,
  input  logic             exit_pend,
  input  logic             sref_ack,
  output logic             do_go,
  output logic             do_pause,
  output logic             do_conf,
  output logic             do_sleep,
  output logic             do_wake
);
  localparam logic [CMD_W-1:0] C_GO    = CMD_W'(OP_GO);
  localparam logic [CMD_W-1:0] C_PAUSE = CMD_W'(OP_PAUSE);
  localparam logic [CMD_W-1:0] C_CONF  = CMD_W'(OP_CONF);
  localparam logic [CMD_W-1:0] C_SLEEP = CMD_W'(OP_SLEEP);
  localparam logic [CMD_W-1:0] C_WAKE  = CMD_W'(OP_WAKE);

  always_comb begin
    do_go    = 1'b0;
    do_pause = 1'b0;
    do_conf  = 1'b0;
    do_sleep = 1'b0;
    do_wake  = 1'b0;
    if (cmd_valid) begin
      unique case (state)
        ST_CFG: do_go = (cmd_code == C_GO);
        ST_RDY: do_pause = (cmd_code == C_PAUSE);
        ST_PAU: begin
          do_go    = (cmd_code == C_GO);
          do_conf  = (cmd_code == C_CONF);
          do_sleep = (cmd_code == C_SLEEP);
        end
        ST_LP:  do_wake = (cmd_code == C_WAKE) && !hw_lp && !exit_pend && sref_ack;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mcps_lp_hshake.sv
module mcps_lp_hshake
  import mcps_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  mc_state_e state,
  input  logic      hw_lp,
  input  logic      exit_pend,
  input  logic      sref_ack,
  input  logic      pwr_req,
  output logic      hw_enter,
  output logic      hw_leave,
  output logic      pwr_ack
);
  logic ack_d, ack_en, in_hw_lp;

  assign in_hw_lp = (state == ST_LP) && hw_lp;
  assign hw_enter = (state == ST_RDY) && !pwr_req;
  assign hw_leave = in_hw_lp && !exit_pend && sref_ack && pwr_req;

  always_comb begin
    ack_en = 1'b0;
    ack_d  = pwr_ack;
    if (in_hw_lp && !exit_pend && sref_ack && !pwr_req) begin
      ack_en = 1'b1;
      ack_d  = 1'b0;
    end else if (in_hw_lp && exit_pend && !sref_ack) begin
      ack_en = 1'b1;
      ack_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pwr_ack <= 1'b1;
    else if (ack_en) pwr_ack <= ack_d;
  end
endmodule

// File: rtl/mcps_fsm.sv
module mcps_fsm
  import mcps_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      do_go,
  input  logic      do_pause,
  input  logic      do_conf,
  input  logic      do_sleep,
  input  logic      do_wake,
  input  logic      hw_enter,
  input  logic      hw_leave,
  input  logic      sref_ack,
  output mc_state_e state,
  output logic      hw_lp,
  output logic      exit_pend
);
  mc_state_e st_d;
  logic      hw_d, ex_d, upd;

  always_comb begin
    st_d = state;
    hw_d = hw_lp;
    ex_d = exit_pend;
    unique case (state)
      ST_CFG: if (do_go) st_d = ST_RDY;
      ST_RDY: begin
        if (hw_enter) begin
          st_d = ST_LP;
          hw_d = 1'b1;
        end else if (do_pause) begin
          st_d = ST_PAU;
        end
      end
      ST_PAU: begin
        if (do_go)        st_d = ST_RDY;
        else if (do_conf) st_d = ST_CFG;
        else if (do_sleep) begin
          st_d = ST_LP;
          hw_d = 1'b0;
        end
      end
      ST_LP: begin
        if (exit_pend && !sref_ack) begin
          st_d = hw_lp ? ST_RDY : ST_PAU;
          hw_d = 1'b0;
          ex_d = 1'b0;
        end else if (do_wake || hw_leave) begin
          ex_d = 1'b1;
        end
      end
      default: st_d = ST_CFG;
    endcase
  end

  assign upd = (st_d != state) || (hw_d != hw_lp) || (ex_d != exit_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CFG;
      hw_lp     <= 1'b0;
      exit_pend <= 1'b0;
    end else if (upd) begin
      state     <= st_d;
      hw_lp     <= hw_d;
      exit_pend <= ex_d;
    end
  end
endmodule

// File: rtl/mc_pwr_seq.sv
module mc_pwr_seq
  import mcps_pkg::*;
#(
  parameter int CMD_W = mcps_pkg::CMD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output logic [1:0]       status,
  output logic             accept,
  input  logic             pwr_req,
  output logic             pwr_ack,
  output logic             pwr_active,
  output logic             sref_req,
  input  logic             sref_ack
);
  logic      rst_s_n;
  mc_state_e state;
  logic      hw_lp, exit_pend;
  logic      do_go, do_pause, do_conf, do_sleep, do_wake;
  logic      hw_enter, hw_leave;

  mcps_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  mcps_cmd_decode #(.CMD_W(CMD_W)) u_dec (
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .state(state),
    .hw_lp(hw_lp), .exit_pend(exit_pend), .sref_ack(sref_ack),
    .do_go(do_go), .do_pause(do_pause), .do_conf(do_conf),
    .do_sleep(do_sleep), .do_wake(do_wake)
  );

  mcps_lp_hshake u_hs (
    .clk(clk), .rst_n(rst_s_n), .state(state), .hw_lp(hw_lp),
    .exit_pend(exit_pend), .sref_ack(sref_ack), .pwr_req(pwr_req),
    .hw_enter(hw_enter), .hw_leave(hw_leave), .pwr_ack(pwr_ack)
  );

  mcps_fsm u_fsm (
    .clk(clk), .rst_n(rst_s_n), .do_go(do_go), .do_pause(do_pause),
    .do_conf(do_conf), .do_sleep(do_sleep), .do_wake(do_wake),
    .hw_enter(hw_enter), .hw_leave(hw_leave), .sref_ack(sref_ack),
    .state(state), .hw_lp(hw_lp), .exit_pend(exit_pend)
  );

  assign status     = state;
  assign accept     = (state == ST_RDY);
  assign pwr_active = (state != ST_LP);
  assign sref_req   = (state == ST_LP) && !exit_pend;
endmodule

// File: rtl/mcps_chk.sv
module mcps_chk #(
  parameter int CMD_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_code,
  input logic [1:0]       status,
  input logic             accept,
  input logic             pwr_req,
  input logic             pwr_ack,
  input logic             sref_req,
  input logic             sref_ack
);
  // R10
  accept_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept == (status == 2'b01));

  // R5
  sref_in_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sref_req |-> status == 2'b11);

  // R8
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_ack) |-> status == 2'b11 && $past(sref_ack) && $past(!pwr_req));

  // R9
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ack) |-> status == 2'b01);

  // R2
  go_from_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == CMD_W'(1) && status == 2'b00 |=> status == 2'b01);

  // R7
  unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_code == CMD_W'(0) || cmd_code > CMD_W'(5)) && pwr_req
      && status != 2'b11 |=> $stable(status));

  // R6
  lp_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'b11 && !sref_req && !sref_ack |=> status != 2'b11);
endmodule

bind mc_pwr_seq mcps_chk #(.CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .status(status), .accept(accept), .pwr_req(pwr_req), .pwr_ack(pwr_ack),
  .sref_req(sref_req), .sref_ack(sref_ack)
);

// File: tb/sim_mc_pwr_seq.sv
`timescale 1ns/1ps
module sim_mc_pwr_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic [1:0] status;
  logic       accept, pwr_ack, pwr_active, sref_req;
  logic       pwr_req = 1'b1;
  logic       sref_ack = 1'b0;
  logic       ack_q1 = 1'b0;
  int         checks = 0, errors = 0, cyc = 0;
  bit         model_on = 1'b0;

  int m_st = 0;
  bit m_hw = 0, m_ex = 0, m_ack = 1;

  always #2 clk = ~clk;

  mc_pwr_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .status(status), .accept(accept), .pwr_req(pwr_req), .pwr_ack(pwr_ack),
    .pwr_active(pwr_active), .sref_req(sref_req), .sref_ack(sref_ack)
  );

  // memory-clock side: acknowledge follows request two cycles later
  always @(posedge clk) begin
    ack_q1   <= sref_req;
    sref_ack <= ack_q1;
  end

  // behavioural reference, states as integers 0..3
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= 0; m_hw <= 0; m_ex <= 0; m_ack <= 1;
    end else if (m_st == 1 && !pwr_req) begin
      m_st <= 3; m_hw <= 1;
    end else if (m_st == 3) begin
      if (m_ex && !sref_ack) begin
        m_st <= m_hw ? 1 : 2; m_ex <= 0; m_hw <= 0;
        if (m_hw) m_ack <= 1;
      end else if (!m_ex && sref_ack) begin
        if (m_hw && pwr_req) m_ex <= 1;
        if (m_hw && !pwr_req) m_ack <= 0;
        if (!m_hw && cmd_valid && cmd_code == 3'd5) m_ex <= 1;
      end
    end else if (cmd_valid) begin
      if (m_st == 0 && cmd_code == 3'd1) m_st <= 1;
      if (m_st == 1 && cmd_code == 3'd2) m_st <= 2;
      if (m_st == 2 && cmd_code == 3'd1) m_st <= 1;
      if (m_st == 2 && cmd_code == 3'd3) m_st <= 0;
      if (m_st == 2 && cmd_code == 3'd4) begin m_st <= 3; m_hw <= 0; end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (model_on && rst_n) begin
      chk("R7 model status", status, m_st);
      chk("R10 model accept", accept, m_st == 1);
      chk("R5 model sref_req", sref_req, m_st == 3 && !m_ex);
      chk("R8 model pwr_ack", pwr_ack, m_ack);
      chk("R5 model pwr_active", pwr_active, m_st != 3);
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(input logic [2:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0; cmd_code = 3'd0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(4);
    model_on = 1'b1;
    // R1
    chk("R1 status", status, 0);
    chk("R1 accept", accept, 0);
    chk("R1 sref_req", sref_req, 0);
    chk("R1 pwr_ack", pwr_ack, 1);
    chk("R1 pwr_active", pwr_active, 1);
    // R7 illegal in Config
    send(3'd2); chk("R7 pause in config", status, 0);
    send(3'd7); chk("R7 code 7", status, 0);
    send(3'd0); chk("R7 code 0", status, 0);
    // R8 no effect outside Ready
    @(negedge clk); pwr_req = 1'b0; idle(3);
    chk("R8 req in config status", status, 0);
    chk("R8 req in config ack", pwr_ack, 1);
    pwr_req = 1'b1; idle(1);
    // R2
    send(3'd1); chk("R2 go", status, 1); chk("R10 accept ready", accept, 1);
    send(3'd4); chk("R5 sleep in ready ignored", status, 1);
    // R3
    send(3'd2); chk("R3 pause", status, 2); chk("R10 accept paused", accept, 0);
    // R5
    send(3'd4); chk("R5 sleep status", status, 3);
    chk("R5 sref_req", sref_req, 1); chk("R5 pwr_active", pwr_active, 0);
    // R6 early wakeup ignored
    send(3'd5); chk("R6 early wake status", status, 3); chk("R6 early wake sref", sref_req, 1);
    idle(3);
    send(3'd5); chk("R6 wake drops sref", sref_req, 0); chk("R6 wake still lp", status, 3);
    idle(4); chk("R6 paused after wake", status, 2);
    send(3'd1); chk("R2 go from paused", status, 1);
    // R11 hardware priority
    @(negedge clk); pwr_req = 1'b0; cmd_valid = 1'b1; cmd_code = 3'd2;
    @(negedge clk); cmd_valid = 1'b0; cmd_code = 3'd0;
    chk("R11 hw wins over pause", status, 3);
    idle(4); chk("R8 ack low", pwr_ack, 0);
    send(3'd5); chk("R11 wake ignored hw", sref_req, 1);
    send(3'd2); chk("R11 pause ignored hw", status, 3);
    // R9
    pwr_req = 1'b1; idle(6);
    chk("R9 ready after release", status, 1); chk("R9 ack high", pwr_ack, 1);
    chk("R9 sref low", sref_req, 0);
    // R4
    send(3'd2); send(3'd3); chk("R4 configure", status, 0);
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cmd_valid = ($urandom_range(0, 3) == 0);
      cmd_code  = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 15) == 0) pwr_req = ~pwr_req;
    end
    @(negedge clk); cmd_valid = 1'b0; pwr_req = 1'b1;
    idle(10);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule